// File: doc/BRIEF.md
# DRAM Address Mapper and Open-Row Tracker

This block sits in front of a DRAM command sequencer. It takes a flat byte address and splits it into rank, bank, row and column fields. A parameter picks one of two field orders. Bank-major order keeps long sequential regions inside one bank. Row-major order rotates through the banks every 16 KiB. In dual-rank builds the rank bit becomes the top bit of a logical bank number, so the two chip-select groups behave as sixteen banks.

The block keeps one entry per logical bank, holding a valid flag and the row that is open in that bank. Each request is classified against this table as a hit (the requested row is open), a miss (the bank is idle) or a conflict (a different row is open, so a precharge is needed first). The sequencer reports back each activate, each single-bank precharge and each precharge-all. Banks therefore stay open until a different row in the same bank is wanted. The decoded fields and the classification come out registered, one cycle after the request strobe.

Top module: `dram_row_mapper`

## Requirements
- R1: With `BANK_MAJOR`=1 the address is read as {rank, bank[2:0], row[14:0], column[9:0], 4 discarded bits}, from the MSB down to the LSB.
- R2: With `BANK_MAJOR`=0 the address is read as {rank, row[14:0], bank[2:0], column[9:0], 4 discarded bits}, so the bank changes every 16384 sequential bytes.
- R3: `col_o` bits [2:0] are always zero. Address bits [3:0] have no effect on any output.
- R4: With `DUAL_RANK`=1, `rank_o` is address bit 32 and `lbank_o` = {rank, bank}, which gives 16 independently tracked logical banks.
- R5: `vld_o` is high exactly one cycle after `req_i`. `wr_o` repeats `wr_i` from that request. When no request is made, the fields hold their previous values. After reset `vld_o` is 0.
- R6: `cls_o`=0 (hit) when the logical bank is open and its stored row equals the requested row.
- R7: `cls_o`=1 (miss) when the logical bank is not open. Reset leaves every bank closed.
- R8: `cls_o`=2 (conflict) when the logical bank is open with a different row. The value 3 never appears.
- R9: `act_i` opens `act_bank_i` with `act_row_i`. `pre_i` closes `pre_bank_i`. `pre_all_i` closes every bank. If an activate and a precharge hit the same bank in one cycle, the activate wins.
- R10: A request is classified against the table as it stood before any update made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| addr_i | input | ADDR_W (33) | Byte address |
| wr_i | input | 1 | 1 = write, 0 = read |
| act_i | input | 1 | Activate done |
| act_bank_i | input | LB_W (4) | Logical bank that was activated |
| act_row_i | input | ROW_W (15) | Row that was activated |
| pre_i | input | 1 | Single-bank precharge done |
| pre_bank_i | input | LB_W (4) | Logical bank that was precharged |
| pre_all_i | input | 1 | Precharge of all banks done |
| vld_o | output | 1 | Registered request valid |
| wr_o | output | 1 | Registered read/write flag |
| rank_o | output | 1 | Rank (chip-select group) |
| bank_o | output | BANK_W (3) | Bank within the rank |
| lbank_o | output | LB_W (4) | Logical bank number |
| row_o | output | ROW_W (15) | Row |
| col_o | output | COL_W (10) | Column, aligned to a burst of 8 |
| cls_o | output | 2 | 0 hit, 1 miss, 2 conflict |

## Verification
The bench drives one stimulus into a bank-major and a row-major instance at the same time. A design with swapped bank and row slices therefore breaks one of the two decodes immediately. It drives low address bits and low column bits to all ones, which catches a column that is not forced to burst alignment. It also uses addresses that differ only in the rank bit, which catches a design that drops the rank from the bank index and so aliases ranks together. Activates and precharges are issued in the same cycle as requests to the same bank. A table that forwards same-cycle updates then reports a hit where a miss is expected. An activate that collides with a precharge-all exposes the wrong update priority as a spurious miss.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;
  typedef enum logic [1:0] {
    CLS_HIT      = 2'd0,
    CLS_MISS     = 2'd1,
    CLS_CONFLICT = 2'd2
  } cls_e;
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int DUAL_RANK  = 1,
  parameter int BANK_MAJOR = 1,
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 15,
  parameter int COL_W      = 10,
  parameter int LSB_W      = 4,
  parameter int BURST_BITS = 3,
  parameter int ADDR_W     = DUAL_RANK + BANK_W + ROW_W + COL_W + LSB_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rank_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  localparam int COL_LO  = LSB_W;
  localparam int MID_LO  = LSB_W + COL_W;
  localparam int BANK_LO = BANK_MAJOR != 0 ? MID_LO + ROW_W : MID_LO;
  localparam int ROW_LO  = BANK_MAJOR != 0 ? MID_LO : MID_LO + BANK_W;
  localparam int RANK_AT = MID_LO + ROW_W + BANK_W;
  localparam int DROP_W  = LSB_W + BURST_BITS;

  assign bank_o = addr_i[BANK_LO +: BANK_W];
  assign row_o  = addr_i[ROW_LO +: ROW_W];
  // burst of 8 is always aligned
  assign col_o  = {addr_i[COL_LO + BURST_BITS +: COL_W - BURST_BITS], {BURST_BITS{1'b0}}};

  logic unused_low;
  assign unused_low = ^addr_i[DROP_W-1:0];

  generate
    if (DUAL_RANK != 0) begin : g_rank
      assign rank_o = addr_i[RANK_AT];
    end else begin : g_single
      assign rank_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dram_open_rows.sv
module dram_open_rows
  import dram_map_pkg::*;
#(
  parameter int LB_W  = 4,
  parameter int ROW_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LB_W-1:0]  lk_bank_i,
  input  logic [ROW_W-1:0] lk_row_i,
  input  logic             act_i,
  input  logic [LB_W-1:0]  act_bank_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic             pre_i,
  input  logic [LB_W-1:0]  pre_bank_i,
  input  logic             pre_all_i,
  output cls_e             lk_cls_o
);
  localparam int NB = 1 << LB_W;

  logic [NB-1:0]    open_q;
  logic [ROW_W-1:0] row_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
      for (int b = 0; b < NB; b++) row_q[b] <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (act_i && act_bank_i == LB_W'(b)) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= act_row_i;
        end else if (pre_all_i || (pre_i && pre_bank_i == LB_W'(b))) begin
          open_q[b] <= 1'b0;
        end
      end
    end
  end

  // lookup sees pre-update state
  always_comb begin
    if (!open_q[lk_bank_i])                lk_cls_o = CLS_MISS;
    else if (row_q[lk_bank_i] == lk_row_i) lk_cls_o = CLS_HIT;
    else                                   lk_cls_o = CLS_CONFLICT;
  end
endmodule

// File: rtl/dram_row_mapper.sv
module dram_row_mapper
  import dram_map_pkg::*;
#(
  parameter int DUAL_RANK  = 1,
  parameter int BANK_MAJOR = 1,
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 15,
  parameter int COL_W      = 10,
  parameter int LSB_W      = 4,
  parameter int BURST_BITS = 3,
  localparam int LB_W      = BANK_W + DUAL_RANK,
  localparam int ADDR_W    = DUAL_RANK + BANK_W + ROW_W + COL_W + LSB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              act_i,
  input  logic [LB_W-1:0]   act_bank_i,
  input  logic [ROW_W-1:0]  act_row_i,
  input  logic              pre_i,
  input  logic [LB_W-1:0]   pre_bank_i,
  input  logic              pre_all_i,
  output logic              vld_o,
  output logic              wr_o,
  output logic              rank_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [LB_W-1:0]   lbank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [1:0]        cls_o
);
  logic              rank_w;
  logic [BANK_W-1:0] bank_w;
  logic [ROW_W-1:0]  row_w;
  logic [COL_W-1:0]  col_w;
  logic [LB_W-1:0]   lbank_w;
  cls_e              cls_w;

  dram_addr_split #(
    .DUAL_RANK (DUAL_RANK),
    .BANK_MAJOR(BANK_MAJOR),
    .BANK_W    (BANK_W),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .LSB_W     (LSB_W),
    .BURST_BITS(BURST_BITS),
    .ADDR_W    (ADDR_W)
  ) u_split (
    .addr_i(addr_i),
    .rank_o(rank_w),
    .bank_o(bank_w),
    .row_o (row_w),
    .col_o (col_w)
  );

  generate
    if (DUAL_RANK != 0) begin : g_lb_dual
      assign lbank_w = {rank_w, bank_w};
    end else begin : g_lb_single
      assign lbank_w = bank_w;
    end
  endgenerate

  dram_open_rows #(
    .LB_W (LB_W),
    .ROW_W(ROW_W)
  ) u_rows (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_bank_i (lbank_w),
    .lk_row_i  (row_w),
    .act_i     (act_i),
    .act_bank_i(act_bank_i),
    .act_row_i (act_row_i),
    .pre_i     (pre_i),
    .pre_bank_i(pre_bank_i),
    .pre_all_i (pre_all_i),
    .lk_cls_o  (cls_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      wr_o    <= 1'b0;
      rank_o  <= 1'b0;
      bank_o  <= '0;
      lbank_o <= '0;
      row_o   <= '0;
      col_o   <= '0;
      cls_o   <= CLS_MISS;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        wr_o    <= wr_i;
        rank_o  <= rank_w;
        bank_o  <= bank_w;
        lbank_o <= lbank_w;
        row_o   <= row_w;
        col_o   <= col_w;
        cls_o   <= cls_w;
      end
    end
  end
endmodule

// File: rtl/dram_row_mapper_chk.sv
module dram_row_mapper_chk #(
  parameter int LB_W       = 4,
  parameter int ROW_W      = 15,
  parameter int COL_W      = 10,
  parameter int BURST_BITS = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             wr_i,
  input logic             act_i,
  input logic [LB_W-1:0]  act_bank_i,
  input logic [ROW_W-1:0] act_row_i,
  input logic             pre_i,
  input logic [LB_W-1:0]  pre_bank_i,
  input logic             pre_all_i,
  input logic             vld_o,
  input logic             wr_o,
  input logic [LB_W-1:0]  lbank_o,
  input logic [ROW_W-1:0] row_o,
  input logic [COL_W-1:0] col_o,
  input logic [1:0]       cls_o
);
  AST_VLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o); // R5
  AST_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o); // R5
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(row_o) && $stable(lbank_o) && $stable(col_o))); // R5
  AST_WR_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (wr_o == $past(wr_i))); // R5
  AST_COL_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (col_o[BURST_BITS-1:0] == '0)); // R3
  AST_CLS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (cls_o != 2'd3)); // R8
  AST_HIT_AFTER_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && $past(act_i)) |=>
      (lbank_o != $past(act_bank_i, 2) || row_o != $past(act_row_i, 2) || cls_o == 2'd0)); // R9
  AST_MISS_AFTER_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && $past(pre_i) && !$past(act_i)) |=>
      (lbank_o != $past(pre_bank_i, 2) || cls_o == 2'd1)); // R9
  AST_MISS_AFTER_PREALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && $past(pre_all_i) && !$past(act_i)) |=> (cls_o == 2'd1)); // R9
endmodule

bind dram_row_mapper dram_row_mapper_chk #(
  .LB_W      (LB_W),
  .ROW_W     (ROW_W),
  .COL_W     (COL_W),
  .BURST_BITS(BURST_BITS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .wr_i      (wr_i),
  .act_i     (act_i),
  .act_bank_i(act_bank_i),
  .act_row_i (act_row_i),
  .pre_i     (pre_i),
  .pre_bank_i(pre_bank_i),
  .pre_all_i (pre_all_i),
  .vld_o     (vld_o),
  .wr_o      (wr_o),
  .lbank_o   (lbank_o),
  .row_o     (row_o),
  .col_o     (col_o),
  .cls_o     (cls_o)
);

// File: tb/dram_row_mapper_bench.sv
`timescale 1ns/1ps
module dram_row_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, act = 1'b0, pre = 1'b0, pre_all = 1'b0;
  logic [32:0] addr = '0;
  logic [3:0]  act_bank = '0, pre_bank = '0;
  logic [14:0] act_row = '0;

  logic        vld_b, wr_b, rank_b, vld_r, wr_r, rank_r;
  logic [2:0]  bank_b, bank_r;
  logic [3:0]  lb_b, lb_r;
  logic [14:0] row_b, row_r;
  logic [9:0]  col_b, col_r;
  logic [1:0]  cls_b, cls_r;

  int checks = 0, fails = 0;
  string tag = "R5";
  bit done = 0;

  always #2 clk = ~clk;

  dram_row_mapper #(.BANK_MAJOR(1)) u_dram_row_mapper (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wr_i(wr),
    .act_i(act), .act_bank_i(act_bank), .act_row_i(act_row),
    .pre_i(pre), .pre_bank_i(pre_bank), .pre_all_i(pre_all),
    .vld_o(vld_b), .wr_o(wr_b), .rank_o(rank_b), .bank_o(bank_b), .lbank_o(lb_b),
    .row_o(row_b), .col_o(col_b), .cls_o(cls_b));

  dram_row_mapper #(.BANK_MAJOR(0)) u_dram_row_mapper_rm (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wr_i(wr),
    .act_i(act), .act_bank_i(act_bank), .act_row_i(act_row),
    .pre_i(pre), .pre_bank_i(pre_bank), .pre_all_i(pre_all),
    .vld_o(vld_r), .wr_o(wr_r), .rank_o(rank_r), .bank_o(bank_r), .lbank_o(lb_r),
    .row_o(row_r), .col_o(col_r), .cls_o(cls_r));

  // behavioural reference
  bit m_open [16];
  int m_row  [16];
  int e_vld, e_wr, e_rank, e_col;
  int e_bank [2];
  int e_lb   [2];
  int e_row  [2];
  int e_cls  [2];

  function automatic int classify(int lb, int rw);
    if (!m_open[lb]) return 1;
    return (m_row[lb] == rw) ? 0 : 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 16; b++) begin m_open[b] = 0; m_row[b] = 0; end
      e_vld = 0;
    end else begin
      e_vld = req;
      if (req) begin
        longint a;
        a = longint'(addr);
        e_wr   = wr;
        e_rank = int'((a >> 32) & 1);
        e_col  = int'((a >> 4) & 1023) & ~7;
        e_bank[0] = int'((a >> 29) & 7);
        e_row[0]  = int'((a >> 14) & 32767);
        e_bank[1] = int'((a >> 14) & 7);
        e_row[1]  = int'((a >> 17) & 32767);
        for (int k = 0; k < 2; k++) begin
          e_lb[k]  = e_rank * 8 + e_bank[k];
          e_cls[k] = classify(e_lb[k], e_row[k]);
        end
      end
      for (int b = 0; b < 16; b++) begin
        if (act && int'(act_bank) == b) begin m_open[b] = 1; m_row[b] = int'(act_row); end
        else if (pre_all || (pre && int'(pre_bank) == b)) m_open[b] = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, got, exp);
    end
  endtask

  function automatic string cls_tag(int c);
    return (c == 0) ? "R6" : (c == 1) ? "R7" : "R8";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(vld_b == e_vld[0], "R5", "vld bank-major", vld_b, e_vld);
      chk(vld_r == e_vld[0], "R5", "vld row-major", vld_r, e_vld);
      if (e_vld != 0) begin
        chk(wr_b == e_wr[0], "R5", "wr", wr_b, e_wr);
        chk(int'(rank_b) == e_rank, "R4", "rank", rank_b, e_rank);
        chk(int'(bank_b) == e_bank[0], "R1", "bank", bank_b, e_bank[0]);
        chk(int'(row_b) == e_row[0], "R1", "row", row_b, e_row[0]);
        chk(int'(lb_b) == e_lb[0], "R4", "lbank", lb_b, e_lb[0]);
        chk(int'(bank_r) == e_bank[1], "R2", "bank", bank_r, e_bank[1]);
        chk(int'(row_r) == e_row[1], "R2", "row", row_r, e_row[1]);
        chk(int'(lb_r) == e_lb[1], "R2", "lbank", lb_r, e_lb[1]);
        chk(int'(col_b) == e_col && int'(col_r) == e_col, "R3", "col", col_b, e_col);
        chk(int'(cls_b) == e_cls[0], {cls_tag(e_cls[0]), " ", tag}, "cls bank-major", cls_b, e_cls[0]);
        chk(int'(cls_r) == e_cls[1], {cls_tag(e_cls[1]), " ", tag}, "cls row-major", cls_r, e_cls[1]);
      end
    end
  end

  function automatic logic [32:0] mk(int rk, int bk, int rw, int cl, int lo);
    return {rk[0], bk[2:0], rw[14:0], cl[9:0], lo[3:0]};
  endfunction

  task automatic step(input bit rq, input logic [32:0] ad, input bit w,
                      input bit ac, input int ab, input int ar,
                      input bit pr, input int pb, input bit pa);
    @(negedge clk);
    req = rq; addr = ad; wr = w;
    act = ac; act_bank = ab[3:0]; act_row = ar[14:0];
    pre = pr; pre_bank = pb[3:0]; pre_all = pa;
  endtask

  task automatic idle();
    step(0, addr, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(vld_b == 1'b0 && vld_r == 1'b0, "R5", "vld in reset", vld_b, 0);
    rst_n = 1'b1;
    idle();
    // R7: fresh table, low bits all ones for R3
    tag = "R7";
    step(1, mk(0, 3, 100, 1023, 15), 1, 0, 0, 0, 0, 0, 0);
    step(1, mk(1, 7, 32767, 8, 15), 0, 0, 0, 0, 0, 0, 0);
    step(1, 33'h1_5555_5555, 1, 0, 0, 0, 0, 0, 0);
    idle(); idle();
    // R6 / R8 after activate
    tag = "R9";
    step(0, addr, 0, 1, 3, 100, 0, 0, 0);
    step(1, mk(0, 3, 100, 7, 0), 0, 0, 0, 0, 0, 0, 0);
    step(1, mk(0, 3, 101, 7, 0), 0, 0, 0, 0, 0, 0, 0);
    // R10: same-cycle activate not visible
    tag = "R10";
    step(1, mk(0, 5, 7, 0, 0), 0, 1, 5, 7, 0, 0, 0);
    step(1, mk(0, 5, 7, 0, 0), 0, 0, 0, 0, 0, 0, 0);
    step(1, mk(0, 5, 7, 0, 0), 0, 0, 0, 0, 1, 5, 0);
    step(1, mk(0, 5, 7, 0, 0), 0, 0, 0, 0, 0, 0, 0);
    // R9: precharge-all with colliding activate
    tag = "R9";
    step(0, addr, 0, 1, 6, 9, 0, 0, 0);
    step(0, addr, 0, 1, 3, 100, 0, 0, 1);
    step(1, mk(0, 3, 100, 0, 0), 0, 0, 0, 0, 0, 0, 0);
    step(1, mk(0, 6, 9, 0, 0), 0, 0, 0, 0, 0, 0, 0);
    step(0, addr, 0, 1, 4, 2, 1, 4, 0);
    step(1, mk(0, 4, 2, 0, 0), 0, 0, 0, 0, 0, 0, 0);
    // R4: ranks are separate banks
    tag = "R4";
    step(0, addr, 0, 1, 11, 9, 0, 0, 0);
    step(1, mk(1, 3, 9, 0, 0), 1, 0, 0, 0, 0, 0, 0);
    step(1, mk(0, 3, 9, 0, 0), 1, 0, 0, 0, 0, 0, 0);
    idle();
    // mixed traffic, small row range to force hits
    tag = "R9 R10";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step($urandom_range(0, 2) != 0,
           mk(int'($urandom_range(0, 1)), int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 1023)), int'($urandom_range(0, 15))),
           $urandom_range(0, 1) != 0,
           r < 25, int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
           r >= 25 && r < 40, int'($urandom_range(0, 15)), r == 99);
    end
    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule